// File: doc/BRIEF.md
# Microcontroller Debug Trigger Unit

This block sits next to an 8-bit microcontroller core and watches the core's fetch and memory buses on every clock. It raises a halt request as soon as any armed trigger sees its condition. There are four triggers. Two compare the address of each fetched instruction against a stored address. One looks up each fetched instruction byte in a 256-bit enable bitmap, so any number of opcode values can be armed at once. One watches data accesses in a chosen memory space: internal data, the special-register space or external data. It qualifies each access on its direction and can also require an exact data value.

A debug agent programs the unit through a simple register write port. Each trigger that fires sets its own bit in a sticky cause register. That bit stays set until the agent writes the clear command. The halt request is high whenever any cause bit is set. Inputs are compared in the cycle they are presented, and the result is registered on the next edge, so tracking the core adds no stall.

Top module: `dbg_trigger_unit`

## Requirements
- R1: Two address triggers are programmed through register 1 (trigger 0) and register 2 (trigger 1), with the address in `cfg_wdata[15:0]`. When `fetch` is high and `fetch_pc` equals the stored address, the trigger sets its cause bit: bit 0 for trigger 0, bit 1 for trigger 1. Both triggers may fire in the same cycle.
- R2: Writing register 5 sets bit `cfg_wdata[7:0]` of the opcode bitmap to the value of `cfg_wdata[8]`. When `fetch` is high and the bitmap bit selected by `fetch_code` is 1, cause bit 2 is set.
- R3: While `fetch` is low, neither `fetch_pc` nor `fetch_code` can set cause bits 0 to 2. This means operand reads never trigger.
- R4: Register 3 holds the watch address in `cfg_wdata[15:0]`. Register 4 holds the watch space in `cfg_wdata[1:0]`, the watch mode in `cfg_wdata[3:2]` and the watch value in `cfg_wdata[15:8]`. Space codes are 0 for internal data, 1 for special registers, 2 for external data and 3 for none. An access matches only if its `mem_space` equals the programmed space. Spaces 0 and 1 compare only `mem_addr[7:0]`. Space 2 compares all 16 bits. Space 3 never matches.
- R5: Mode 0 fires on any write (`mem_wr`) to the watched address. Mode 1 fires on any read (`mem_rd`) from it. In both modes the data is ignored. A watch hit sets cause bit 3.
- R6: Mode 2 fires only on a write whose `mem_wdata` equals the watch value. Mode 3 fires only on a read whose `mem_rdata` equals the watch value. The data bus of the other direction has no effect.
- R7: Register 0 bits 0 to 3 enable the triggers in cause-bit order. A disabled trigger never sets its cause bit.
- R8: A match presented in cycle N appears in `cause` and `halt` after the next rising edge. Cause bits are sticky, and `halt` is high exactly when `cause` is non-zero.
- R9: Any write to register 6 clears `cause` and `halt` on that edge. A match in the same cycle is still recorded.
- R10: After reset, `cause` is 0, `halt` is low, all enables and stored addresses are 0, and the opcode bitmap is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| fetch | input | 1 | Opcode fetch strobe from the core |
| fetch_pc | input | 16 | Address of the byte being fetched |
| fetch_code | input | 8 | Fetched opcode byte |
| mem_rd | input | 1 | Data read strobe |
| mem_wr | input | 1 | Data write strobe |
| mem_space | input | 2 | Space of the data access (0 internal, 1 special, 2 external) |
| mem_addr | input | 16 | Data access address |
| mem_rdata | input | 8 | Data returned by a read |
| mem_wdata | input | 8 | Data driven by a write |
| halt | output | 1 | Halt request to the core |
| cause | output | 4 | Sticky trigger record {watch, opcode, addr1, addr0} |

## Verification
Every result is due exactly one rising edge after its stimulus. The bench drives each fetch or access on a falling edge and removes it on the next falling edge. It reads `cause` and `halt` at that same moment, which is after the single registering edge. One check also reads `halt` before that edge, to confirm that nothing appears early. Configuration writes take effect at the edge inside their one-cycle window, so a stimulus that follows them sees the new setting. The clear command is issued in the same way and is checked both alone and together with a new match.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;

  localparam int NUM_ADDR_TRIG = 2;
  localparam int CAUSE_W       = NUM_ADDR_TRIG + 2;
  localparam int OP_BIT        = NUM_ADDR_TRIG;
  localparam int WATCH_BIT     = NUM_ADDR_TRIG + 1;

  typedef enum logic [2:0] {
    REG_ENABLE = 3'd0,
    REG_ADDR0  = 3'd1,
    REG_ADDR1  = 3'd2,
    REG_WADDR  = 3'd3,
    REG_WCFG   = 3'd4,
    REG_OPMAP  = 3'd5,
    REG_CLEAR  = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    SP_IDATA = 2'd0,
    SP_SFR   = 2'd1,
    SP_XDATA = 2'd2,
    SP_NONE  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    WM_ANY_WR  = 2'd0,
    WM_ANY_RD  = 2'd1,
    WM_DATA_WR = 2'd2,
    WM_DATA_RD = 2'd3
  } wmode_e;

endpackage

// File: rtl/dbgt_addr_cmp.sv
module dbgt_addr_cmp #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          enable,
  input  logic          fetch,
  input  logic [AW-1:0] pc,
  output logic          hit
);

  logic [AW-1:0] bp_q;

  always_ff @(posedge clk) begin
    if (rst)       bp_q <= '0;
    else if (load) bp_q <= load_addr;
  end

  assign hit = enable && fetch && (pc == bp_q);

endmodule

// File: rtl/dbgt_opcode_map.sv
module dbgt_opcode_map #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_op,
  input  logic          load_val,
  input  logic          enable,
  input  logic          fetch,
  input  logic [DW-1:0] code,
  output logic          hit
);

  localparam int NUM_OPS = 1 << DW;

  logic [NUM_OPS-1:0] map_q;

  always_ff @(posedge clk) begin
    if (rst)       map_q <= '0;
    else if (load) map_q[load_op] <= load_val;
  end

  assign hit = enable && fetch && map_q[code];

endmodule

// File: rtl/dbgt_watch_cmp.sv
module dbgt_watch_cmp
  import dbgt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_addr,
  input  logic [AW-1:0] new_addr,
  input  logic          load_cfg,
  input  logic [1:0]    new_space,
  input  logic [1:0]    new_mode,
  input  logic [DW-1:0] new_value,
  input  logic          enable,
  input  logic [1:0]    bus_space,
  input  logic [AW-1:0] bus_addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] wdata,
  output logic          hit
);

  logic [AW-1:0] addr_q;
  space_e        space_q;
  wmode_e        mode_q;
  logic [DW-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      space_q <= SP_IDATA;
      mode_q  <= WM_ANY_WR;
      value_q <= '0;
    end else begin
      if (load_addr) addr_q <= new_addr;
      if (load_cfg) begin
        space_q <= space_e'(new_space);
        mode_q  <= wmode_e'(new_mode);
        value_q <= new_value;
      end
    end
  end

  logic space_ok, addr_ok, kind_ok;

  always_comb begin
    space_ok = (space_q != SP_NONE) && (bus_space == space_q);
    if (space_q == SP_XDATA) addr_ok = (bus_addr == addr_q);
    else                     addr_ok = (bus_addr[DW-1:0] == addr_q[DW-1:0]);
    case (mode_q)
      WM_ANY_WR:  kind_ok = wr;
      WM_ANY_RD:  kind_ok = rd;
      WM_DATA_WR: kind_ok = wr && (wdata == value_q);
      default:    kind_ok = rd && (rdata == value_q);
    endcase
  end

  assign hit = enable && space_ok && addr_ok && kind_ok;

endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
  import dbgt_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int CFG_AW = 3,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              fetch,
  input  logic [AW-1:0]     fetch_pc,
  input  logic [DW-1:0]     fetch_code,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [1:0]        mem_space,
  input  logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [DW-1:0]     mem_wdata,
  output logic              halt,
  output logic [CAUSE_W-1:0] cause
);

  localparam int VAL_LO = CFG_W - DW;

  logic [CAUSE_W-1:0] enable_q;
  logic [CAUSE_W-1:0] hits;
  logic [CAUSE_W-1:0] cause_q;
  logic               halt_q;

  logic wr_enable, wr_waddr, wr_wcfg, wr_opmap, clr;
  assign wr_enable = cfg_we && (cfg_addr == CFG_AW'(REG_ENABLE));
  assign wr_waddr  = cfg_we && (cfg_addr == CFG_AW'(REG_WADDR));
  assign wr_wcfg   = cfg_we && (cfg_addr == CFG_AW'(REG_WCFG));
  assign wr_opmap  = cfg_we && (cfg_addr == CFG_AW'(REG_OPMAP));
  assign clr       = cfg_we && (cfg_addr == CFG_AW'(REG_CLEAR));

  always_ff @(posedge clk) begin
    if (rst)            enable_q <= '0;
    else if (wr_enable) enable_q <= cfg_wdata[CAUSE_W-1:0];
  end

  for (genvar i = 0; i < NUM_ADDR_TRIG; i++) begin : g_addr
    localparam int SEL = int'(REG_ADDR0) + i;
    dbgt_addr_cmp #(.AW(AW)) u_cmp (
      .clk       (clk),
      .rst       (rst),
      .load      (cfg_we && (cfg_addr == CFG_AW'(SEL))),
      .load_addr (cfg_wdata[AW-1:0]),
      .enable    (enable_q[i]),
      .fetch     (fetch),
      .pc        (fetch_pc),
      .hit       (hits[i])
    );
  end

  dbgt_opcode_map #(.DW(DW)) u_opmap (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_opmap),
    .load_op  (cfg_wdata[DW-1:0]),
    .load_val (cfg_wdata[DW]),
    .enable   (enable_q[OP_BIT]),
    .fetch    (fetch),
    .code     (fetch_code),
    .hit      (hits[OP_BIT])
  );

  dbgt_watch_cmp #(.AW(AW), .DW(DW)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .load_addr (wr_waddr),
    .new_addr  (cfg_wdata[AW-1:0]),
    .load_cfg  (wr_wcfg),
    .new_space (cfg_wdata[1:0]),
    .new_mode  (cfg_wdata[3:2]),
    .new_value (cfg_wdata[VAL_LO +: DW]),
    .enable    (enable_q[WATCH_BIT]),
    .bus_space (mem_space),
    .bus_addr  (mem_addr),
    .rd        (mem_rd),
    .wr        (mem_wr),
    .rdata     (mem_rdata),
    .wdata     (mem_wdata),
    .hit       (hits[WATCH_BIT])
  );

  logic [CAUSE_W-1:0] cause_d;
  assign cause_d = (clr ? '0 : cause_q) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      halt_q  <= |cause_d;
    end
  end

  assign cause = cause_q;
  assign halt  = halt_q;

  // R8: any hit raises the halt request on the next edge
  a_r8_hit_raises_halt: assert property (@(posedge clk) disable iff (rst)
    (|hits) |=> halt);

  // R8: recorded causes survive until a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((cause & $past(cause)) == $past(cause)));

  // R9: clear without a new match empties the record
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|hits)) |=> (cause == '0 && !halt));

  // R3: no fetch strobe, no change on fetch-driven cause bits
  a_r3_fetch_gates: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !clr) |=> (cause[OP_BIT:0] == $past(cause[OP_BIT:0])));

  // R5: no data strobe, no change on the watch cause bit
  a_r5_strobe_gates: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd && !mem_wr && !clr) |=> (cause[WATCH_BIT] == $past(cause[WATCH_BIT])));

  // R7: a disabled trigger leaves its cause bit alone
  for (genvar k = 0; k < CAUSE_W; k++) begin : g_en_chk
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
      (!enable_q[k] && !clr) |=> (cause[k] == $past(cause[k])));
  end

endmodule

// File: tb/tb_dbg_trigger_unit.sv
module tb_dbg_trigger_unit;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic        fetch = 0;
  logic [15:0] fetch_pc = 0;
  logic [7:0]  fetch_code = 0;
  logic        mem_rd = 0, mem_wr = 0;
  logic [1:0]  mem_space = 0;
  logic [15:0] mem_addr = 0;
  logic [7:0]  mem_rdata = 0, mem_wdata = 0;
  logic        halt;
  logic [3:0]  cause;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbg_trigger_unit dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fetch(fetch), .fetch_pc(fetch_pc), .fetch_code(fetch_code),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_space(mem_space), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .halt(halt), .cause(cause)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_cause();
    cfg_write(3'd6, 16'h0);
  endtask

  task automatic do_fetch(input logic [15:0] pc, input logic [7:0] op, input logic f);
    @(negedge clk);
    fetch_pc = pc; fetch_code = op; fetch = f;
    @(negedge clk);
    fetch = 0;
  endtask

  task automatic do_access(input logic [1:0] sp, input logic [15:0] a, input logic rd,
                           input logic wr, input logic [7:0] rdat, input logic [7:0] wdat);
    @(negedge clk);
    mem_space = sp; mem_addr = a; mem_rd = rd; mem_wr = wr;
    mem_rdata = rdat; mem_wdata = wdat;
    @(negedge clk);
    mem_rd = 0; mem_wr = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    chk("R10 cause after reset", 16'(cause), 16'h0);
    chk("R10 halt after reset", 16'(halt), 16'h0);

    // R10: bitmap empty after reset, opcode trigger armed alone
    cfg_write(3'd0, 16'h4);
    for (int op = 0; op < 256; op++) begin
      do_fetch(16'h8000 | 16'(op), 8'(op), 1'b1);
      chk("R10 empty opcode map", 16'(cause), 16'h0);
    end

    // R1: address triggers
    cfg_write(3'd1, 16'h1234);
    cfg_write(3'd2, 16'hABCD);
    cfg_write(3'd0, 16'h3);
    // R8: nothing before the edge, halt after it
    @(negedge clk);
    fetch_pc = 16'h1234; fetch = 1;
    #1 chk("R8 halt not early", 16'(halt), 16'h0);
    @(negedge clk);
    fetch = 0;
    chk("R8 halt one edge later", 16'(halt), 16'h1);
    chk("R1 trigger 0 hit", 16'(cause), 16'h1);
    repeat (3) @(negedge clk);
    chk("R8 cause sticky", 16'(cause), 16'h1);
    chk("R8 halt sticky", 16'(halt), 16'h1);
    clear_cause();
    chk("R9 clear cause", 16'(cause), 16'h0);
    chk("R9 clear halt", 16'(halt), 16'h0);
    do_fetch(16'hABCD, 8'h00, 1'b1);
    chk("R1 trigger 1 hit", 16'(cause), 16'h2);
    clear_cause();
    for (int b = 0; b < 16; b++) begin
      do_fetch(16'h1234 ^ (16'h1 << b), 8'h00, 1'b1);
      chk("R1 near miss trigger 0", 16'(cause), 16'h0);
      do_fetch(16'hABCD ^ (16'h1 << b), 8'h00, 1'b1);
      chk("R1 near miss trigger 1", 16'(cause), 16'h0);
    end
    // R3: operand read at a breakpoint address
    do_fetch(16'h1234, 8'h00, 1'b0);
    chk("R3 no fetch no address hit", 16'(cause), 16'h0);
    // R7: disabled trigger 0
    cfg_write(3'd0, 16'h2);
    do_fetch(16'h1234, 8'h00, 1'b1);
    chk("R7 disabled trigger 0", 16'(cause), 16'h0);
    do_fetch(16'hABCD, 8'h00, 1'b1);
    chk("R7 trigger 1 still armed", 16'(cause), 16'h2);
    clear_cause();
    // R1: both at the same address
    cfg_write(3'd0, 16'h3);
    cfg_write(3'd2, 16'h1234);
    do_fetch(16'h1234, 8'h00, 1'b1);
    chk("R1 both triggers", 16'(cause), 16'h3);
    clear_cause();

    // R2: opcode bitmap with op % 5 == 0 armed
    for (int op = 0; op < 256; op++)
      cfg_write(3'd5, {7'h0, (op % 5 == 0), 8'(op)});
    cfg_write(3'd0, 16'h4);
    for (int op = 0; op < 256; op++) begin
      do_fetch(16'h8000 | 16'(op), 8'(op), 1'b1);
      chk("R2 opcode sweep", 16'(cause), (op % 5 == 0) ? 16'h4 : 16'h0);
      if (op % 5 == 0) clear_cause();
    end
    do_fetch(16'h8000, 8'h00, 1'b0);
    chk("R3 operand byte no opcode hit", 16'(cause), 16'h0);
    cfg_write(3'd5, 16'h0000);
    do_fetch(16'h8000, 8'h00, 1'b1);
    chk("R2 bitmap bit cleared", 16'(cause), 16'h0);
    cfg_write(3'd0, 16'h0);
    do_fetch(16'h8000, 8'h05, 1'b1);
    chk("R7 opcode disabled", 16'(cause), 16'h0);

    // R4 R5 R6: watch sweep
    cfg_write(3'd3, 16'h3C5A);
    for (int cs = 0; cs < 4; cs++) begin
      for (int m = 0; m < 4; m++) begin
        cfg_write(3'd4, {8'h96, 4'h0, 2'(m), 2'(cs)});
        for (int en = 0; en < 2; en++) begin
          cfg_write(3'd0, en ? 16'h8 : 16'h0);
          for (int bs = 0; bs < 3; bs++)
            for (int dir = 0; dir < 2; dir++)
              for (int ad = 0; ad < 3; ad++)
                for (int dm = 0; dm < 2; dm++) begin
                  logic [15:0] a;
                  logic [7:0]  own, other;
                  logic addr_ok, dir_ok, data_ok, exp_hit;
                  a = (ad == 0) ? 16'h3C5A : (ad == 1) ? (16'h3C5A ^ 16'h4100) : (16'h3C5A ^ 16'h0001);
                  own   = (dm == 0) ? 8'h96 : 8'h69;
                  other = (dm == 0) ? 8'h00 : 8'h96;
                  addr_ok = (ad == 0) || (ad == 1 && cs != 2);
                  dir_ok  = (m == 0 || m == 2) ? (dir == 1) : (dir == 0);
                  data_ok = (m < 2) || (dm == 0);
                  exp_hit = (en == 1) && (cs < 3) && (bs == cs) && addr_ok && dir_ok && data_ok;
                  if (dir == 1) do_access(2'(bs), a, 1'b0, 1'b1, other, own);
                  else          do_access(2'(bs), a, 1'b1, 1'b0, own, other);
                  if (en == 0)       chk("R7 watch disabled", 16'(cause), 16'h0);
                  else if (cs == 3)  chk("R4 space none", 16'(cause), 16'h0);
                  else if (m < 2)    chk("R5 any access mode", 16'(cause), exp_hit ? 16'h8 : 16'h0);
                  else               chk("R6 data mode", 16'(cause), exp_hit ? 16'h8 : 16'h0);
                  if (ad == 1 && bs == cs && en == 1 && cs < 3 && dir_ok && data_ok)
                    chk("R4 address width", 16'(cause), (cs == 2) ? 16'h0 : 16'h8);
                  if (exp_hit) clear_cause();
                end
        end
      end
    end

    // R9: clear together with a new match
    cfg_write(3'd0, 16'h3);
    cfg_write(3'd2, 16'hABCD);
    do_fetch(16'h1234, 8'h00, 1'b1);
    chk("R9 setup hit", 16'(cause), 16'h1);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'd6; cfg_wdata = 0;
    fetch_pc = 16'hABCD; fetch = 1;
    @(negedge clk);
    cfg_we = 0; fetch = 0;
    chk("R9 clear keeps same-cycle hit", 16'(cause), 16'h2);
    chk("R9 halt stays with new hit", 16'(halt), 16'h1);
    clear_cause();
    chk("R9 final clear", 16'(cause), 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule